// File: doc/BRIEF.md
# Per-Channel ABCD Signaling Debouncer

This block keeps the robbed-bit ABCD signaling state for a set of time-multiplexed voice channels. A valid/ready stream delivers the most recent ABCD nibble for each channel as the framer extracts it. Each channel holds an 8-bit state: a buffered input nibble and a buffered output nibble. On a multiframe-end pulse, debounced mode moves each output bit only when the input has agreed with itself across two consecutive multiframes. On a D-bit-update pulse, direct mode copies the newest input into both nibbles at once.

Updates run as a scan that visits one channel per clock. While a scan is running, the input stream is held off. Every output change sets a sticky interrupt. Channels whose stack enable is set can log their new ABCD values into a 32-entry change stack, which is read out through a second valid/ready stream. A processor-driven freeze pin stops all buffer and stack updates. The interrupt keeps working while the pin is high.

Back-pressure rules: the input side accepts a nibble on any clock where `in_valid` and `in_ready` are both high. `in_ready` is low for exactly the scan cycles that follow an accepted update pulse. On the stack side, the head entry stays stable while `stk_valid` is high and `stk_ready` is low.

Top module: `abcd_sig_debounce`

## Requirements
- R1: After reset every channel state reads 0x00. Debounced mode is selected, the stack mode is "changes", and all stack enables are clear. The freeze pin, the interrupt, the overflow flag and `stk_valid` are low, and `in_ready` is high.
- R2: An input beat (`in_valid` and `in_ready`) stores the nibble as the latest input of `in_chan` and leaves the readable state unchanged. `in_ready` is low for the NUM_CH cycles after an accepted update pulse.
- R3: In debounced mode, a `mf_end` pulse sets each output bit to the latest input bit where the latest input bit equals the buffered input bit, and keeps the output bit otherwise. The buffered input then takes the latest input.
- R4: In direct mode, a `dbit_upd` pulse loads both the buffered input and the buffered output with the latest input.
- R5: A pulse that belongs to the mode not selected has no effect, and so does a pulse that arrives during a scan. The mode is bit 0 of register 0 (1 = debounced).
- R6: `rd_sig` returns `{output nibble, buffered input nibble}` of channel `rd_chan` combinationally. Only the channel being updated changes.
- R7: A write to register 1 with bit 0 set drives `frz_pin` high. With only bit 1 set, the write drives it low. Bit 0 wins when both are set, and with neither set the pin holds its level.
- R8: While `frz_pin` is high, no channel state changes and nothing is pushed onto the stack.
- R9: `frz_irq` is set by any update that would change a channel's output nibble, even while frozen. It is cleared by writing register 3 with bit 0 set, and a set in the same cycle wins over the clear.
- R10: A write to register 2 stores bit 0 as the stack enable of `reg_chan`. Register 0 bits [2:1] select the stack mode: 0 pushes nothing, 1 pushes output changes, and 2 or 3 pushes every update. Each entry carries the channel and its new output nibble.
- R11: The stack pops in first-in first-out order. While it is stalled, the head entry is held.
- R12: With 32 entries queued, further pushes are dropped and `stk_ovf` is set. `stk_ovf` stays set until register 3 is written with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input nibble valid |
| in_ready | output | 1 | Input can be accepted (low during a scan) |
| in_chan | input | CHW | Channel of the input nibble |
| in_abcd | input | 4 | ABCD input nibble |
| mf_end | input | 1 | Multiframe-end pulse (debounced update) |
| dbit_upd | input | 1 | D-bit update pulse (direct update) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 config, 1 freeze, 2 stack enable, 3 clear |
| reg_chan | input | CHW | Channel for a stack-enable write |
| reg_wdata | input | 3 | Register write data |
| rd_chan | input | CHW | Channel to read back |
| rd_sig | output | 8 | Channel state {output, buffered input} |
| frz_pin | output | 1 | Freeze output level |
| frz_irq | output | 1 | Sticky output-change interrupt |
| stk_valid | output | 1 | Stack head valid |
| stk_ready | input | 1 | Stack pop |
| stk_chan | output | CHW | Channel of the head entry |
| stk_abcd | output | 4 | ABCD value of the head entry |
| stk_ovf | output | 1 | Sticky stack overflow |

## Verification
On every cycle, the assertions check the freeze pin's set and hold rules and the stickiness of the interrupt and overflow flags. They also check that the stack head holds while stalled, that the readable state stays fixed while frozen, and that `in_ready` drops after an accepted pulse. The per-bit debounce outcome, the rule that the unselected pulse is ignored, the stack's mode and enable filtering, FIFO ordering, and the exact overflow threshold can only be seen through the bench's scenarios. Those scenarios compare read-back values against results computed by hand.

// File: rtl/sigdeb_pkg.sv
package sigdeb_pkg;

  typedef enum logic [1:0] {
    RA_CFG   = 2'd0,
    RA_FRZ   = 2'd1,
    RA_STKEN = 2'd2,
    RA_CLR   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SM_NONE = 2'd0,
    SM_CHG  = 2'd1,
    SM_ALLA = 2'd2,
    SM_ALLB = 2'd3
  } stk_mode_e;

  // Per-bit two-multiframe agreement rule.
  function automatic logic [3:0] deb_merge(input logic [3:0] latest,
                                           input logic [3:0] prev_in,
                                           input logic [3:0] cur_out);
    logic [3:0] agree;
    agree = ~(latest ^ prev_in);
    return (agree & latest) | (~agree & cur_out);
  endfunction

endpackage

// File: rtl/sigdeb_ctrl.sv
module sigdeb_ctrl
  import sigdeb_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [CHW-1:0]    reg_chan,
  input  logic [2:0]        reg_wdata,
  input  logic              irq_set,
  output logic              deb_en,
  output logic [1:0]        stk_mode,
  output logic [NUM_CH-1:0] stk_en,
  output logic              frz_pin,
  output logic              frz_irq,
  output logic              ovf_clr
);

  logic wr_cfg, wr_frz, wr_en, wr_clr;

  always_comb begin
    wr_cfg  = reg_wr && (reg_addr == RA_CFG);
    wr_frz  = reg_wr && (reg_addr == RA_FRZ);
    wr_en   = reg_wr && (reg_addr == RA_STKEN);
    wr_clr  = reg_wr && (reg_addr == RA_CLR);
    ovf_clr = wr_clr && reg_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_en   <= 1'b1;
      stk_mode <= SM_CHG;
      frz_pin  <= 1'b0;
      frz_irq  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        deb_en   <= reg_wdata[0];
        stk_mode <= reg_wdata[2:1];
      end
      if (wr_frz) begin
        if (reg_wdata[0])      frz_pin <= 1'b1;
        else if (reg_wdata[1]) frz_pin <= 1'b0;
      end
      if (irq_set)                   frz_irq <= 1'b1;
      else if (wr_clr && reg_wdata[0]) frz_irq <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              stk_en[c] <= 1'b0;
      else if (wr_en && reg_chan == CHW'(c))   stk_en[c] <= reg_wdata[0];
    end
  end

endmodule

// File: rtl/sigdeb_scan.sv
module sigdeb_scan #(
  parameter int NUM_CH = 32,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_deb,
  output logic           busy,
  output logic [CHW-1:0] cur_ch,
  output logic           cur_deb
);

  localparam logic [CHW-1:0] LAST = CHW'(NUM_CH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_ch  <= '0;
      cur_deb <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        cur_ch  <= '0;
        cur_deb <= start_deb;
      end
    end else if (cur_ch == LAST) begin
      busy <= 1'b0;
    end else begin
      cur_ch <= cur_ch + 1'b1;
    end
  end

endmodule

// File: rtl/sigdeb_fifo.sv
module sigdeb_fifo #(
  parameter int DEPTH = 32,
  parameter int W = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_ready,
  input  logic         ovf_clr,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  output logic         ovf
);

  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          full, do_push, do_pop;

  always_comb begin
    full      = (cnt == (AW+1)'(DEPTH));
    pop_valid = (cnt != '0);
    do_push   = push && !full;
    do_pop    = pop_valid && pop_ready;
    pop_data  = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/abcd_sig_debounce.sv
module abcd_sig_debounce
  import sigdeb_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int STK_DEPTH = 32,
  localparam int CHW = $clog2(NUM_CH),
  localparam int ENT_W = CHW + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CHW-1:0] in_chan,
  input  logic [3:0]     in_abcd,
  input  logic           mf_end,
  input  logic           dbit_upd,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [CHW-1:0] reg_chan,
  input  logic [2:0]     reg_wdata,
  input  logic [CHW-1:0] rd_chan,
  output logic [7:0]     rd_sig,
  output logic           frz_pin,
  output logic           frz_irq,
  output logic           stk_valid,
  input  logic           stk_ready,
  output logic [CHW-1:0] stk_chan,
  output logic [3:0]     stk_abcd,
  output logic           stk_ovf
);

  logic              deb_en, ovf_clr, irq_set;
  logic [1:0]        stk_mode;
  logic [NUM_CH-1:0] stk_en;
  logic              scan_busy, cur_deb, start;
  logic [CHW-1:0]    cur_ch;
  logic [3:0]        lat_arr [NUM_CH];
  logic [7:0]        sig_arr [NUM_CH];
  logic [3:0]        cur_lat, new_out;
  logic [7:0]        cur_sig;
  logic              changed, upd, push;
  logic [ENT_W-1:0]  pop_data;

  sigdeb_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_chan(reg_chan), .reg_wdata(reg_wdata), .irq_set(irq_set),
    .deb_en(deb_en), .stk_mode(stk_mode), .stk_en(stk_en),
    .frz_pin(frz_pin), .frz_irq(frz_irq), .ovf_clr(ovf_clr)
  );

  always_comb start = (mf_end && deb_en) || (dbit_upd && !deb_en);

  sigdeb_scan #(.NUM_CH(NUM_CH)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .start_deb(deb_en),
    .busy(scan_busy), .cur_ch(cur_ch), .cur_deb(cur_deb)
  );

  always_comb begin
    in_ready = !scan_busy;
    cur_lat  = lat_arr[cur_ch];
    cur_sig  = sig_arr[cur_ch];
    new_out  = cur_deb ? deb_merge(cur_lat, cur_sig[3:0], cur_sig[7:4]) : cur_lat;
    changed  = scan_busy && (new_out != cur_sig[7:4]);
    irq_set  = changed;
    upd      = scan_busy && !frz_pin;
    case (stk_mode)
      SM_NONE: push = 1'b0;
      SM_CHG:  push = upd && stk_en[cur_ch] && changed;
      default: push = upd && stk_en[cur_ch];
    endcase
    rd_sig = sig_arr[rd_chan];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [3:0] lat_q;
    logic [7:0] sig_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q <= '0;
        sig_q <= '0;
      end else begin
        if (in_valid && in_ready && in_chan == CHW'(g)) lat_q <= in_abcd;
        if (upd && cur_ch == CHW'(g))                   sig_q <= {new_out, cur_lat};
      end
    end
    assign lat_arr[g] = lat_q;
    assign sig_arr[g] = sig_q;
  end

  sigdeb_fifo #(.DEPTH(STK_DEPTH), .W(ENT_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data({cur_ch, new_out}),
    .pop_ready(stk_ready), .ovf_clr(ovf_clr), .pop_valid(stk_valid),
    .pop_data(pop_data), .ovf(stk_ovf)
  );

  always_comb begin
    stk_chan = pop_data[ENT_W-1:4];
    stk_abcd = pop_data[3:0];
  end

endmodule

// File: rtl/abcd_sig_debounce_chk.sv
module abcd_sig_debounce_chk #(
  parameter int CHW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [1:0]     reg_addr,
  input logic [2:0]     reg_wdata,
  input logic           mf_end,
  input logic           deb_en,
  input logic           in_ready,
  input logic [CHW-1:0] rd_chan,
  input logic [7:0]     rd_sig,
  input logic           frz_pin,
  input logic           frz_irq,
  input logic           stk_valid,
  input logic           stk_ready,
  input logic [CHW-1:0] stk_chan,
  input logic [3:0]     stk_abcd,
  input logic           stk_ovf
);

  // R7
  frz_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[0]) |=> frz_pin);

  // R7
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd1) |=> $stable(frz_pin));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_irq && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> frz_irq);

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_ovf && !(reg_wr && reg_addr == 2'd3 && reg_wdata[1])) |=> stk_ovf);

  // R11
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_chan) && $stable(stk_abcd)));

  // R8
  frozen_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frz_pin) && $stable(rd_chan)) |-> $stable(rd_sig));

  // R2
  scan_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_end && deb_en && in_ready) |=> !in_ready);

endmodule

bind abcd_sig_debounce abcd_sig_debounce_chk #(.CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mf_end(mf_end), .deb_en(deb_en), .in_ready(in_ready),
  .rd_chan(rd_chan), .rd_sig(rd_sig), .frz_pin(frz_pin), .frz_irq(frz_irq),
  .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_chan(stk_chan),
  .stk_abcd(stk_abcd), .stk_ovf(stk_ovf)
);

// File: tb/abcd_sig_debounce_bench.sv
module abcd_sig_debounce_bench;

  localparam int NUM_CH = 32;
  localparam int CHW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [CHW-1:0] in_chan = '0;
  logic [3:0] in_abcd = '0;
  logic mf_end = 1'b0, dbit_upd = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [CHW-1:0] reg_chan = '0;
  logic [2:0] reg_wdata = '0;
  logic [CHW-1:0] rd_chan = '0;
  logic [7:0] rd_sig;
  logic frz_pin, frz_irq, stk_valid, stk_ovf;
  logic stk_ready = 1'b0;
  logic [CHW-1:0] stk_chan;
  logic [3:0] stk_abcd;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic rdy_mid;

  always #2 clk = ~clk;

  abcd_sig_debounce u_abcd_sig_debounce (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_abcd(in_abcd), .mf_end(mf_end), .dbit_upd(dbit_upd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_chan(reg_chan), .reg_wdata(reg_wdata),
    .rd_chan(rd_chan), .rd_sig(rd_sig), .frz_pin(frz_pin), .frz_irq(frz_irq),
    .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_chan(stk_chan),
    .stk_abcd(stk_abcd), .stk_ovf(stk_ovf)
  );

  // {debounced, is_mf_end, input nibble, expected state of channel 5}
  localparam logic [13:0] VEC [11] = '{
    {1'b1, 1'b1, 4'h6, 8'h06},
    {1'b1, 1'b1, 4'h6, 8'h66},
    {1'b1, 1'b1, 4'hA, 8'h6A},
    {1'b1, 1'b1, 4'hA, 8'hAA},
    {1'b1, 1'b1, 4'h5, 8'hA5},
    {1'b1, 1'b1, 4'hF, 8'hFF},
    {1'b0, 1'b0, 4'h3, 8'h33},
    {1'b0, 1'b0, 4'h8, 8'h88},
    {1'b0, 1'b1, 4'h2, 8'h88},
    {1'b1, 1'b0, 4'h1, 8'h88},
    {1'b1, 1'b1, 4'h1, 8'h81}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [CHW-1:0] c, input logic [2:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_chan = c; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic send_in(input int c, input logic [3:0] v);
    in_valid = 1'b1; in_chan = CHW'(c); in_abcd = v;
    while (!in_ready) tick();
    tick();
    in_valid = 1'b0;
  endtask

  task automatic pulse(input bit is_mf);
    if (is_mf) mf_end = 1'b1; else dbit_upd = 1'b1;
    tick();
    mf_end = 1'b0; dbit_upd = 1'b0;
    rdy_mid = in_ready;
    repeat (NUM_CH + 1) tick();
  endtask

  task automatic read_ch(input int c, output logic [7:0] v);
    rd_chan = CHW'(c);
    #1;
    v = rd_sig;
  endtask

  task automatic pop();
    stk_ready = 1'b1;
    tick();
    stk_ready = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 in_ready", 16'(in_ready), 16'h1);
    chk("R1 frz_pin", 16'(frz_pin), 16'h0);
    chk("R1 frz_irq", 16'(frz_irq), 16'h0);
    chk("R1 stk_valid", 16'(stk_valid), 16'h0);
    chk("R1 stk_ovf", 16'(stk_ovf), 16'h0);
    read_ch(0, v);  chk("R1 ch0", 16'(v), 16'h00);
    read_ch(31, v); chk("R1 ch31", 16'(v), 16'h00);

    // R1 debounced by default: D-bit pulse ignored, multiframe pulse debounces
    send_in(2, 4'hF);
    read_ch(2, v); chk("R2 input write leaves state", 16'(v), 16'h00);
    pulse(1'b0);
    read_ch(2, v); chk("R1 R5 dbit ignored by default", 16'(v), 16'h00);
    pulse(1'b1);
    chk("R2 in_ready low mid scan", 16'(rdy_mid), 16'h0);
    read_ch(2, v); chk("R1 R3 default debounce", 16'(v), 16'h0F);

    // vector walk on channel 5
    for (int i = 0; i < 11; i++) begin
      string tag;
      reg_write(2'd0, '0, {2'b01, VEC[i][13]});
      send_in(5, VEC[i][11:8]);
      pulse(VEC[i][12]);
      if (VEC[i][13] && VEC[i][12])        tag = "R3 debounce vector";
      else if (!VEC[i][13] && !VEC[i][12]) tag = "R4 direct vector";
      else                                  tag = "R5 wrong-mode pulse";
      read_ch(5, v);
      chk(tag, 16'(v), 16'(VEC[i][7:0]));
    end
    read_ch(6, v); chk("R6 other channel untouched", 16'(v), 16'h00);

    // R9 sticky interrupt and clear
    chk("R9 irq after changes", 16'(frz_irq), 16'h1);
    reg_write(2'd3, '0, 3'b001);
    chk("R9 irq cleared", 16'(frz_irq), 16'h0);
    pulse(1'b1);
    read_ch(5, v); chk("R3 settle", 16'(v), 16'h11);
    chk("R9 irq on change", 16'(frz_irq), 16'h1);
    reg_write(2'd3, '0, 3'b001);
    pulse(1'b1);
    chk("R9 no change keeps irq clear", 16'(frz_irq), 16'h0);

    // R7 R8 freeze
    reg_write(2'd0, '0, 3'b010);
    reg_write(2'd1, '0, 3'b001);
    chk("R7 freeze on", 16'(frz_pin), 16'h1);
    send_in(5, 4'hC);
    pulse(1'b0);
    read_ch(5, v); chk("R8 frozen state held", 16'(v), 16'h11);
    chk("R9 irq while frozen", 16'(frz_irq), 16'h1);
    reg_write(2'd1, '0, 3'b010);
    chk("R7 freeze off", 16'(frz_pin), 16'h0);
    reg_write(2'd1, '0, 3'b011);
    chk("R7 on wins", 16'(frz_pin), 16'h1);
    reg_write(2'd1, '0, 3'b000);
    chk("R7 hold", 16'(frz_pin), 16'h1);
    reg_write(2'd1, '0, 3'b010);
    chk("R7 off again", 16'(frz_pin), 16'h0);
    pulse(1'b0);
    read_ch(5, v); chk("R4 after unfreeze", 16'(v), 16'hCC);

    // R10 stack filtering
    reg_write(2'd2, 5'd7, 3'b001);
    send_in(7, 4'h9);
    send_in(8, 4'h9);
    pulse(1'b0);
    chk("R10 push valid", 16'(stk_valid), 16'h1);
    chk("R10 entry chan", 16'(stk_chan), 16'h7);
    chk("R10 entry abcd", 16'(stk_abcd), 16'h9);
    pop();
    chk("R10 disabled channel not pushed", 16'(stk_valid), 16'h0);
    pulse(1'b0);
    chk("R10 no push without change", 16'(stk_valid), 16'h0);
    reg_write(2'd0, '0, 3'b100);
    pulse(1'b0);
    send_in(7, 4'h3);
    pulse(1'b0);
    chk("R11 head first", 16'(stk_abcd), 16'h9);
    pop();
    chk("R11 second entry", 16'(stk_abcd), 16'h3);
    pop();
    chk("R11 drained", 16'(stk_valid), 16'h0);

    // R12 overflow
    for (int c = 0; c < NUM_CH; c++) reg_write(2'd2, CHW'(c), 3'b001);
    pulse(1'b0);
    chk("R12 full no overflow", 16'(stk_ovf), 16'h0);
    pulse(1'b0);
    chk("R12 overflow set", 16'(stk_ovf), 16'h1);
    chk("R11 oldest head chan", 16'(stk_chan), 16'h0);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (stk_valid) begin
        cnt++;
        pop();
      end
    end
    chk("R12 depth kept", 16'(cnt), 16'd32);
    chk("R12 overflow sticky", 16'(stk_ovf), 16'h1);
    reg_write(2'd3, '0, 3'b010);
    chk("R12 overflow cleared", 16'(stk_ovf), 16'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule